// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns an interrupt's addressing information into a delivery bitmask with one bit per local interrupt agent. The caller supplies a 32-bit destination, a physical/logical mode bit, a two-bit shorthand code and the index of the requesting agent. Each agent describes itself through its own inputs:

- present flag
- extended-mode flag
- 8-bit legacy ID
- 32-bit initial ID
- 32-bit logical destination
- 4-bit logical model

Every agent is matched by the rule of its own mode, so agents in legacy and extended mode can be mixed in one system.

The agent count is a parameter. The number of mask bit positions (slots) is that count rounded up to a multiple of 32, and the mask is presented as an array of 32-bit words. Slots past the agent count, and agents whose present flag is low, never appear in the mask. The mask is registered: it reflects the inputs of the previous clock cycle. Choosing among several targets for lowest-priority delivery, and delivering the vector itself, are left to the logic around this block.

Top module: `dest_resolver`

## Requirements
- R1: With shorthand 0, a destination of 0xFFFFFFFF selects every present agent in extended mode, and no legacy-mode agent. This holds whichever value the mode bit has.
- R2: With shorthand 0 and the mode bit at 0 (physical):
  - an extended-mode agent matches when its 32-bit initial ID equals the whole destination;
  - a legacy-mode agent matches when its legacy ID equals destination bits [7:0];
  - the legacy ID of an extended-mode agent is ignored.
- R3: In physical mode, a destination equal to 0x000000FF selects every present legacy-mode agent, in addition to any direct ID match.
- R4: With shorthand 0 and the mode bit at 1 (logical), an extended-mode agent matches when both of these hold:
  - destination bits [31:16] equal logical-destination bits [31:16];
  - destination bits [15:0] and logical-destination bits [15:0] have at least one set bit in common.
- R5: In logical mode, a legacy-mode agent matches according to its model, using destination bits [7:0] and logical-destination bits [7:0]:
  - model 0xF (flat): the two bytes share any set bit;
  - model 0x0 (cluster): the upper nibbles are equal and the lower nibbles share a set bit;
  - any other model: the agent never matches.
- R6: Shorthand 2 selects every present agent, and the destination and mode bit are ignored.
- R7: Shorthand 1 sets only the mask bit whose slot equals the requester's own ID.
- R8: Shorthand 3 selects every present agent except the slot equal to the requester's own ID.
- R9: The requester's own ID for R7 and R8 depends on the requester's mode:
  - in extended mode, it is the requester's initial ID;
  - in legacy mode, it is the requester's legacy ID.
- R10: An agent whose present flag is low, and any slot at or past the agent count, is never set in the mask, under any shorthand.
- R11: The mask reflects the inputs sampled at the previous rising clock edge. It is all zero while rst_ni is low. Slot k is bit k%32 of word k/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dest_i | input | 32 | Destination field |
| logical_i | input | 1 | 0 physical, 1 logical |
| shorthand_i | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| self_idx_i | input | IDX_W | Index of the requesting agent |
| agent_present_i | input | N_AGENTS | Agent exists |
| agent_ext_i | input | N_AGENTS | Agent is in extended mode |
| agent_legacy_id_i | input | N_AGENTS x 8 | Legacy ID per agent |
| agent_init_id_i | input | N_AGENTS x 32 | Initial ID per agent |
| agent_ldest_i | input | N_AGENTS x 32 | Logical destination per agent |
| agent_model_i | input | N_AGENTS x 4 | Logical model per agent |
| mask_o | output | N_WORDS x 32 | Delivery bitmask, one bit per slot |

## Verification
The block holds no state beyond the output register, so a wrong internal decision shows up in mask_o on the first cycle after the offending inputs. Each such fault appears as a wrong bit in a specific slot:
- A matcher that applies the wrong mode's rule sets or drops one agent's bit.
- A mis-decoded requester ID moves the self bit, or the hole in the all-but-self mask, to a neighbouring slot.
- A missing present gate leaks an absent slot.

The agent configuration deliberately gives some agents IDs that differ from their slot, and mixes both modes. This lets each of these faults be told apart one cycle after the stimulus is applied.

// File: rtl/dest_resolver_pkg.sv
`timescale 1ns/1ps
package dest_resolver_pkg;
  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0]  MODEL_FLAT    = 4'hF;
  localparam logic [3:0]  MODEL_CLUSTER = 4'h0;
  localparam logic [31:0] EXT_BCAST     = 32'hFFFF_FFFF;
  localparam logic [31:0] LEG_BCAST     = 32'h0000_00FF;

  function automatic int unsigned round_up32(int unsigned n);
    return ((n + 31) / 32) * 32;
  endfunction
endpackage

// File: rtl/dest_agent_match.sv
`timescale 1ns/1ps
module dest_agent_match
  import dest_resolver_pkg::*;
(
  input  logic [31:0] dest_i,
  input  logic        logical_i,
  input  logic        present_i,
  input  logic        ext_i,
  input  logic [7:0]  legacy_id_i,
  input  logic [31:0] init_id_i,
  input  logic [31:0] ldest_i,
  input  logic [3:0]  model_i,
  output logic        hit_o
);
  logic phys_hit, log_hit, leg_log_hit;

  always_comb begin
    if (ext_i) phys_hit = (init_id_i == dest_i);
    else       phys_hit = (legacy_id_i == dest_i[7:0]) || (dest_i == LEG_BCAST);
  end

  always_comb begin
    unique case (model_i)
      MODEL_FLAT:    leg_log_hit = |(dest_i[7:0] & ldest_i[7:0]);
      MODEL_CLUSTER: leg_log_hit = (dest_i[7:4] == ldest_i[7:4]) &&
                                   (|(dest_i[3:0] & ldest_i[3:0]));
      default:       leg_log_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (ext_i) log_hit = (dest_i[31:16] == ldest_i[31:16]) &&
                         (|(dest_i[15:0] & ldest_i[15:0]));
    else       log_hit = leg_log_hit;
  end

  // extended broadcast overrides both modes and excludes legacy agents
  always_comb begin
    if (dest_i == EXT_BCAST) hit_o = present_i & ext_i;
    else if (logical_i)      hit_o = present_i & log_hit;
    else                     hit_o = present_i & phys_hit;
  end
endmodule

// File: rtl/dest_self_locate.sv
`timescale 1ns/1ps
module dest_self_locate #(
  parameter int unsigned N_AGENTS = 40,
  parameter int unsigned N_SLOTS  = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic [IDX_W-1:0]             self_idx_i,
  input  logic [N_AGENTS-1:0]          ext_i,
  input  logic [N_AGENTS-1:0][7:0]     legacy_id_i,
  input  logic [N_AGENTS-1:0][31:0]    init_id_i,
  output logic [N_SLOTS-1:0]           self_mask_o
);
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic               idx_ok;
  logic [IDX_W-1:0]   idx_safe;
  logic [31:0]        own_id;

  assign idx_ok   = (32'(self_idx_i) < N_AGENTS);
  assign idx_safe = idx_ok ? self_idx_i : '0;

  always_comb begin
    if (ext_i[idx_safe]) own_id = init_id_i[idx_safe];
    else                 own_id = {24'h0, legacy_id_i[idx_safe]};
  end

  always_comb begin
    self_mask_o = '0;
    if (idx_ok && (own_id < N_SLOTS)) self_mask_o[own_id[SLOT_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/dest_resolver.sv
`timescale 1ns/1ps
module dest_resolver
  import dest_resolver_pkg::*;
#(
  parameter int unsigned N_AGENTS = 40,
  localparam int unsigned N_SLOTS = round_up32(N_AGENTS),
  localparam int unsigned N_WORDS = N_SLOTS / 32,
  localparam int unsigned IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [31:0]                   dest_i,
  input  logic                          logical_i,
  input  logic [1:0]                    shorthand_i,
  input  logic [IDX_W-1:0]              self_idx_i,
  input  logic [N_AGENTS-1:0]           agent_present_i,
  input  logic [N_AGENTS-1:0]           agent_ext_i,
  input  logic [N_AGENTS-1:0][7:0]      agent_legacy_id_i,
  input  logic [N_AGENTS-1:0][31:0]     agent_init_id_i,
  input  logic [N_AGENTS-1:0][31:0]     agent_ldest_i,
  input  logic [N_AGENTS-1:0][3:0]      agent_model_i,
  output logic [N_WORDS-1:0][31:0]      mask_o
);
  logic [N_SLOTS-1:0] hit, present_pad, legacy_pad, self_mask, mask_d, mask_q;
  shorthand_e sh;

  assign sh = shorthand_e'(shorthand_i);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    if (s < N_AGENTS) begin : g_agent
      dest_agent_match u_match (
        .dest_i      (dest_i),
        .logical_i   (logical_i),
        .present_i   (agent_present_i[s]),
        .ext_i       (agent_ext_i[s]),
        .legacy_id_i (agent_legacy_id_i[s]),
        .init_id_i   (agent_init_id_i[s]),
        .ldest_i     (agent_ldest_i[s]),
        .model_i     (agent_model_i[s]),
        .hit_o       (hit[s])
      );
      assign present_pad[s] = agent_present_i[s];
      assign legacy_pad[s]  = agent_present_i[s] & ~agent_ext_i[s];
    end else begin : g_pad
      assign hit[s]         = 1'b0;
      assign present_pad[s] = 1'b0;
      assign legacy_pad[s]  = 1'b0;
    end
  end

  dest_self_locate #(
    .N_AGENTS (N_AGENTS),
    .N_SLOTS  (N_SLOTS),
    .IDX_W    (IDX_W)
  ) u_self (
    .self_idx_i  (self_idx_i),
    .ext_i       (agent_ext_i),
    .legacy_id_i (agent_legacy_id_i),
    .init_id_i   (agent_init_id_i),
    .self_mask_o (self_mask)
  );

  always_comb begin
    unique case (sh)
      SH_FIELD:  mask_d = hit;
      SH_SELF:   mask_d = self_mask & present_pad;
      SH_ALL:    mask_d = present_pad;
      SH_OTHERS: mask_d = present_pad & ~self_mask;
      default:   mask_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign mask_o[w] = mask_q[w*32 +: 32];
  end

  // R10
  a_r10_no_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((mask_q & ~$past(present_pad)) == '0));
  // R1
  a_r1_xbcast_no_legacy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh == SH_FIELD && dest_i == EXT_BCAST) |=> ((mask_q & $past(legacy_pad)) == '0));
  // R7
  a_r7_self_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh == SH_SELF) |=> ($countones(mask_q) <= 1));
  // R8
  a_r8_others_skip_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh == SH_OTHERS) |=> ((mask_q & $past(self_mask)) == '0));
  // R6
  a_r6_all_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh == SH_ALL) |=> (mask_q == $past(present_pad)));
endmodule

// File: tb/dest_resolver_bench.sv
`timescale 1ns/1ps
module dest_resolver_bench;
  localparam int NA = 40;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [31:0]          dest_i = '0;
  logic                 logical_i = 1'b0;
  logic [1:0]           shorthand_i = 2'd0;
  logic [5:0]           self_idx_i = '0;
  logic [NA-1:0]        present, ext;
  logic [NA-1:0][7:0]   lid;
  logic [NA-1:0][31:0]  iid, ldest;
  logic [NA-1:0][3:0]   model;
  logic [1:0][31:0]     mask_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  dest_resolver #(.N_AGENTS(NA)) u_dest_resolver (
    .clk_i, .rst_ni, .dest_i, .logical_i, .shorthand_i, .self_idx_i,
    .agent_present_i   (present),
    .agent_ext_i       (ext),
    .agent_legacy_id_i (lid),
    .agent_init_id_i   (iid),
    .agent_ldest_i     (ldest),
    .agent_model_i     (model),
    .mask_o
  );

  task automatic check(string req, logic [63:0] exp);
    logic [63:0] act;
    act = {mask_o[1], mask_o[0]};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mask %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] d, logic lg, logic [1:0] sh, logic [5:0] idx,
                       string req, logic [63:0] exp);
    @(negedge clk_i);
    dest_i = d; logical_i = lg; shorthand_i = sh; self_idx_i = idx;
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, exp);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    shorthand_i = 2'd2;
    @(negedge clk_i);
    check("R11 reset", 64'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_physical();
    apply(32'd3,          1'b0, 2'd0, 6'd0, "R2 legacy id",         64'h0000_0000_0000_0008);
    apply(32'h0000_0103,  1'b0, 2'd0, 6'd0, "R2 low byte only",     64'h0000_0000_0000_0008);
    apply(32'd35,         1'b0, 2'd0, 6'd0, "R2 ext full id",       64'h0000_0008_0000_0000);
    apply(32'd2,          1'b0, 2'd0, 6'd0, "R2 mixed modes",       64'h0000_0002_0000_0004);
    apply(32'd5,          1'b0, 2'd0, 6'd0, "R10 absent agent",     64'h0);
    apply(32'h0000_00FF,  1'b0, 2'd0, 6'd0, "R3 legacy broadcast",  64'h0000_0000_FFFF_FFDF);
  endtask

  task automatic t_ext_bcast();
    apply(32'hFFFF_FFFF, 1'b0, 2'd0, 6'd0, "R1 physical",          64'h0000_00FF_0000_0000);
    apply(32'hFFFF_FFFF, 1'b1, 2'd0, 6'd0, "R1 logical",           64'h0000_00FF_0000_0000);
  endtask

  task automatic t_logical();
    apply(32'h0000_0006, 1'b1, 2'd0, 6'd0, "R5 flat",              64'h0000_0000_0000_0006);
    apply(32'h0000_0013, 1'b1, 2'd0, 6'd0, "R5 cluster",           64'h0000_0000_0000_0313);
    apply(32'h0000_00FF, 1'b1, 2'd0, 6'd0, "R5 other model",       64'h0000_0000_0000_00DF);
    apply(32'h0002_0005, 1'b1, 2'd0, 6'd0, "R4 ext cluster",       64'h0000_0050_0000_0005);
  endtask

  task automatic t_shorthand();
    apply(32'hFFFF_FFFF, 1'b0, 2'd1, 6'd3,  "R7 self legacy",      64'h0000_0000_0000_0008);
    apply(32'd0,         1'b0, 2'd1, 6'd20, "R9 self legacy id",   64'h0000_0000_0040_0000);
    apply(32'd0,         1'b1, 2'd1, 6'd33, "R9 self init id",     64'h0000_0000_0000_0004);
    apply(32'd0,         1'b0, 2'd1, 6'd5,  "R10 self absent",     64'h0);
    apply(32'd7,         1'b1, 2'd2, 6'd0,  "R6 all",              64'h0000_00FF_FFFF_FFDF);
    apply(32'd0,         1'b0, 2'd3, 6'd20, "R8 others legacy",    64'h0000_00FF_FFBF_FFDF);
    apply(32'd0,         1'b0, 2'd3, 6'd33, "R8 others ext",       64'h0000_00FF_FFFF_FFDB);
    apply(32'd0,         1'b0, 2'd3, 6'd39, "R8 others top",       64'h0000_007F_FFFF_FFDF);
  endtask

  initial begin
    for (int i = 0; i < NA; i++) begin
      present[i] = (i != 5);
      ext[i]     = (i >= 32);
      lid[i]     = 8'(i);
      iid[i]     = 32'(i);
      if (i < 8) begin
        model[i] = 4'hF; ldest[i] = 32'(1 << i);
      end else if (i < 16) begin
        model[i] = 4'h0; ldest[i] = {24'h0, 4'(1 + (i - 8) / 4), 4'(1 << (i % 4))};
      end else if (i < 32) begin
        model[i] = 4'h5; ldest[i] = 32'h0000_00FF;
      end else begin
        model[i] = 4'hF; ldest[i] = {16'(1 + (i - 32) / 4), 16'(1 << (i % 4))};
      end
    end
    lid[20] = 8'd22;
    iid[33] = 32'd2;
    lid[36] = 8'd3;

    t_reset();
    t_physical();
    t_ext_bcast();
    t_logical();
    t_shorthand();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: done %0d expected 1", done);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule